// File: doc/BRIEF.md
# Sector DMA Transfer Sequencer

This block moves data between a disk store organised in 512-byte sectors and an 18-bit byte-addressed system memory. A register block outside it starts a transfer with a pulse, a function code, a packed disk address, a signed word count, an 18-bit starting memory address and an address-hold flag. The packed disk address holds the sector, surface, cylinder and drive. From it the sequencer forms a linear sector index and a byte offset on the disk. It then works through the transfer one sector chunk at a time, with at most 512 bytes in each chunk. Every chunk passes through an internal staging buffer. A write transfer gathers memory bytes into the buffer and then writes them to the disk. A read transfer fills the buffer from the disk and then writes it to memory.

After each chunk the sequencer advances the sector, surface and cylinder. When the transfer ends it returns the rewritten disk address, the advanced memory address and the error flags. The register block stores these values back into its own registers. Before it starts each chunk, the sequencer checks that the chunk lies inside the disk capacity. A chunk that does not stops the transfer and raises the error flags. Both ports are plain synchronous RAM ports with one cycle of read latency.

Top module: `sectorDmaSeq`

## Requirements
- R1: A `start` pulse is taken only while `busy` is low. `busy` rises in the cycle after the pulse is taken and stays high through the cycle in which `done` is high. A `start` pulse seen while `busy` is high has no effect on the transfer in progress or on its results.
- R2: The length of the transfer in bytes is twice the magnitude of `wordCount`, read as a two's-complement number. A negative value is negated first, so 16'hFF00 and 16'h0100 both give 512 bytes, and 16'h8000 gives 65536 bytes.
- R3: The packed disk address holds the sector in bits 3:0, the surface in bit 4, the cylinder in bits 12:5 and the drive in bits 15:13. The track is bits 12:4. The disk byte address of byte k in a chunk is (track*12 + sector)*512 + k, and the drive field plays no part in it.
- R4: A chunk holds min(512, bytes left) bytes. After each chunk the sector increases by one. When the result would be 12 or more, the sector becomes 0 and the surface toggles. When the surface toggles from 1 to 0, the cylinder increases by one, modulo 256.
- R5: The memory address is 18 bits wide and increases by one for each byte moved, wrapping modulo 2^18. `busAddrOut` equals the start address plus the number of bytes moved.
- R6: When `inhibitInc` is high at start, every memory access uses the start address and `busAddrOut` equals the start address.
- R7: For function codes 1 and 2, `diskAddrOut` is sector | surface<<4 | cylinder<<5, using the geometry reached at the end, with bits 15:13 set to zero.
- R8: Before each chunk, a linear index (track*12 + sector) at or above `DISK_SECTORS` stops the transfer. The stop sets `errSector` to 1 and `errCs` to 2'b11, and no port access follows. The results show only the chunks that completed.
- R9: Function code 1 (write) copies memory bytes to consecutive disk bytes. Function code 2 (read) copies disk bytes to consecutive memory bytes. The data arrives unchanged.
- R10: A zero word count with function code 1 or 2 completes with no port access. The sector, surface and cylinder come back unchanged, and the memory address is unchanged.
- R11: Any function code other than 1 or 2 completes with no port access. It returns `diskAddrIn` and `busAddrIn` unchanged and leaves the error flags clear.
- R12: After reset, `busy`, `done`, both request lines, the error flags and the results are all zero. `done` is a one-cycle pulse. `diskAddrOut` and `busAddrOut` hold their values while `busy` is low.
- R13: Read data appears on `memRdata` or `dskRdata` one cycle after the request. The memory request and the disk request are never both high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| func | input | 3 | Function: 1 write (memory to disk), 2 read (disk to memory), others no transfer |
| diskAddrIn | input | 16 | Packed disk address |
| wordCount | input | 16 | Two's-complement word count |
| busAddrIn | input | 18 | Starting memory byte address |
| inhibitInc | input | 1 | Hold the memory address fixed |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| diskAddrOut | output | 16 | Rewritten disk address |
| busAddrOut | output | 18 | Final memory address |
| errSector | output | 1 | Sector beyond capacity |
| errCs | output | 2 | Summary error bits, 2'b11 on error |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 18 | Memory byte address |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, one cycle after the request |
| dskReq | output | 1 | Disk access request |
| dskWe | output | 1 | Disk write enable |
| dskAddr | output | DSK_AW | Disk byte address |
| dskWdata | output | 8 | Disk write data |
| dskRdata | input | 8 | Disk read data, one cycle after the request |

## Verification
The bench drives transfers that cross a sector-to-surface wrap and a surface-to-cylinder wrap, and one that starts at sector 13. A design that compared against 11 instead of "12 or more" would hand back the wrong disk address. Other transfers carry the memory address across bit 16 and past 2^18, which exposes a truncated or non-wrapping address counter. A transfer of 600 bytes shows whether the second chunk has the right partial length. A transfer that runs off the end of the disk after one good chunk, and the 16'h8000 word count, show whether the capacity check stops the transfer at the right chunk and keeps the progress already made. The directed tests cover a copy from memory to disk and back, address hold (a wrong design writes successive bytes instead of overwriting one), a start ignored while busy, and zero-length and unknown-function requests that must touch neither port.

// File: rtl/sdmaPkg.sv
package sdmaPkg;

  localparam int SECTOR_BYTES    = 512;
  localparam int SECTORS_PER_TRK = 12;
  localparam int IDX_W           = $clog2(SECTOR_BYTES) + 1;
  localparam int LIN_W           = 13;

  localparam logic [2:0] FN_WRITE = 3'd1;
  localparam logic [2:0] FN_READ  = 3'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FILL_REQ,
    ST_FILL_CAP,
    ST_DRAIN,
    ST_NEXT,
    ST_FINISH
  } seqState_e;

  typedef struct packed {
    logic load;
    logic commit;
    logic flagErr;
    logic chunkSetup;
    logic srcRead;
    logic capture;
    logic drain;
    logic stepGeo;
  } seqStrobe_t;

endpackage

// File: rtl/sdmaCtrl.sv
module sdmaCtrl
  import sdmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       funcValid,
  input  logic       remZero,
  input  logic       outOfRange,
  input  logic       lastByte,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       done
);

  seqState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.load  = 1'b1;
          nextState = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!funcValid || remZero) begin
          stb.commit = 1'b1;
          nextState  = ST_FINISH;
        end else if (outOfRange) begin
          stb.commit  = 1'b1;
          stb.flagErr = 1'b1;
          nextState   = ST_FINISH;
        end else begin
          stb.chunkSetup = 1'b1;
          nextState      = ST_FILL_REQ;
        end
      end
      ST_FILL_REQ: begin
        stb.srcRead = 1'b1;
        nextState   = ST_FILL_CAP;
      end
      ST_FILL_CAP: begin
        stb.capture = 1'b1;
        nextState   = lastByte ? ST_DRAIN : ST_FILL_REQ;
      end
      ST_DRAIN: begin
        stb.drain = 1'b1;
        if (lastByte) nextState = ST_NEXT;
      end
      ST_NEXT: begin
        stb.stepGeo = 1'b1;
        nextState   = ST_CHECK;
      end
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

endmodule

// File: rtl/sdmaDatapath.sv
module sdmaDatapath
  import sdmaPkg::*;
#(
  parameter int DISK_SECTORS = 4872,
  parameter int DSK_AW       = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [2:0]        func,
  input  logic [15:0]       diskAddrIn,
  input  logic [15:0]       wordCount,
  input  logic [17:0]       busAddrIn,
  input  logic              inhibitInc,
  output logic              funcValid,
  output logic              remZero,
  output logic              outOfRange,
  output logic              lastByte,
  output logic [15:0]       diskAddrOut,
  output logic [17:0]       busAddrOut,
  output logic              errSector,
  output logic [1:0]        errCs,
  output logic              memReq,
  output logic              memWe,
  output logic [17:0]       memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              dskReq,
  output logic              dskWe,
  output logic [DSK_AW-1:0] dskAddr,
  output logic [7:0]        dskWdata,
  input  logic [7:0]        dskRdata
);

  localparam int LEN_W  = 17;
  localparam int BUF_AW = $clog2(SECTOR_BYTES);

  logic             isWrite;
  logic             holdAddr;
  logic [15:0]      daHold;
  logic [3:0]       sec;
  logic             surf;
  logic [7:0]       cyl;
  logic [LEN_W-1:0] remaining;
  logic [IDX_W-1:0] curLen;
  logic [IDX_W-1:0] idx;
  logic [17:0]      addrReg;
  logic [7:0]       chunkBuf [SECTOR_BYTES];

  logic [15:0]      wcMag;
  logic [LEN_W-1:0] byteLen;
  logic [LIN_W-1:0] linIdx;
  logic [7:0]       fillData;
  logic [7:0]       bufOut;

  // Word count magnitude; 16'h8000 yields 32768 unsigned.
  assign wcMag   = wordCount[15] ? (~wordCount + 16'd1) : wordCount;
  assign byteLen = {wcMag, 1'b0};

  assign linIdx     = LIN_W'({cyl, surf}) * LIN_W'(SECTORS_PER_TRK) + LIN_W'(sec);
  assign outOfRange = int'(linIdx) >= DISK_SECTORS;
  assign remZero    = (remaining == '0);
  assign lastByte   = (idx == curLen - IDX_W'(1));

  assign fillData = isWrite ? memRdata : dskRdata;
  assign bufOut   = chunkBuf[idx[BUF_AW-1:0]];

  // Port drive: sources read during fill, destinations written during drain.
  assign memReq   = (stb.srcRead & isWrite) | (stb.drain & ~isWrite);
  assign memWe    = stb.drain & ~isWrite;
  assign memAddr  = addrReg;
  assign memWdata = bufOut;
  assign dskReq   = (stb.srcRead & ~isWrite) | (stb.drain & isWrite);
  assign dskWe    = stb.drain & isWrite;
  assign dskAddr  = DSK_AW'({linIdx, {BUF_AW{1'b0}}}) + DSK_AW'(idx);
  assign dskWdata = bufOut;

  always_ff @(posedge clk) begin
    if (stb.capture) chunkBuf[idx[BUF_AW-1:0]] <= fillData;
  end

  // Transfer control registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isWrite   <= 1'b0;
      funcValid <= 1'b0;
      holdAddr  <= 1'b0;
      daHold    <= '0;
      remaining <= '0;
      curLen    <= '0;
      idx       <= '0;
    end else begin
      if (stb.load) begin
        isWrite   <= (func == FN_WRITE);
        funcValid <= (func == FN_WRITE) || (func == FN_READ);
        holdAddr  <= inhibitInc;
        daHold    <= diskAddrIn;
        remaining <= byteLen;
      end
      if (stb.chunkSetup) begin
        curLen <= (remaining >= LEN_W'(SECTOR_BYTES)) ? IDX_W'(SECTOR_BYTES)
                                                      : remaining[IDX_W-1:0];
        idx    <= '0;
      end
      if (stb.capture || stb.drain)
        idx <= lastByte ? '0 : idx + IDX_W'(1);
      if (stb.stepGeo)
        remaining <= remaining - LEN_W'(curLen);
    end
  end

  // Geometry walk: sector, then surface, then cylinder.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sec  <= '0;
      surf <= 1'b0;
      cyl  <= '0;
    end else if (stb.load) begin
      sec  <= diskAddrIn[3:0];
      surf <= diskAddrIn[4];
      cyl  <= diskAddrIn[12:5];
    end else if (stb.stepGeo) begin
      if (sec >= 4'(SECTORS_PER_TRK - 1)) begin
        sec  <= '0;
        surf <= ~surf;
        if (surf) cyl <= cyl + 8'd1;
      end else begin
        sec <= sec + 4'd1;
      end
    end
  end

  // Memory address counter with hold option.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (stb.load) begin
      addrReg <= busAddrIn;
    end else if (!holdAddr) begin
      if ((stb.capture && isWrite) || (stb.drain && !isWrite))
        addrReg <= addrReg + 18'd1;
    end
  end

  // Results and error flags.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diskAddrOut <= '0;
      busAddrOut  <= '0;
      errSector   <= 1'b0;
      errCs       <= '0;
    end else begin
      if (stb.load) begin
        errSector <= 1'b0;
        errCs     <= '0;
      end
      if (stb.commit) begin
        diskAddrOut <= funcValid ? {3'b000, cyl, surf, sec} : daHold;
        busAddrOut  <= addrReg;
      end
      if (stb.flagErr) begin
        errSector <= 1'b1;
        errCs     <= 2'b11;
      end
    end
  end

endmodule

// File: rtl/sectorDmaSeq.sv
module sectorDmaSeq
  import sdmaPkg::*;
#(
  parameter  int DISK_SECTORS = 4872,
  localparam int DSK_AW       = $clog2(DISK_SECTORS * SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        func,
  input  logic [15:0]       diskAddrIn,
  input  logic [15:0]       wordCount,
  input  logic [17:0]       busAddrIn,
  input  logic              inhibitInc,
  output logic              busy,
  output logic              done,
  output logic [15:0]       diskAddrOut,
  output logic [17:0]       busAddrOut,
  output logic              errSector,
  output logic [1:0]        errCs,
  output logic              memReq,
  output logic              memWe,
  output logic [17:0]       memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              dskReq,
  output logic              dskWe,
  output logic [DSK_AW-1:0] dskAddr,
  output logic [7:0]        dskWdata,
  input  logic [7:0]        dskRdata
);

  seqStrobe_t stb;
  logic funcValid, remZero, outOfRange, lastByte;

  sdmaCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .funcValid  (funcValid),
    .remZero    (remZero),
    .outOfRange (outOfRange),
    .lastByte   (lastByte),
    .stb        (stb),
    .busy       (busy),
    .done       (done)
  );

  sdmaDatapath #(
    .DISK_SECTORS (DISK_SECTORS),
    .DSK_AW       (DSK_AW)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .func        (func),
    .diskAddrIn  (diskAddrIn),
    .wordCount   (wordCount),
    .busAddrIn   (busAddrIn),
    .inhibitInc  (inhibitInc),
    .funcValid   (funcValid),
    .remZero     (remZero),
    .outOfRange  (outOfRange),
    .lastByte    (lastByte),
    .diskAddrOut (diskAddrOut),
    .busAddrOut  (busAddrOut),
    .errSector   (errSector),
    .errCs       (errCs),
    .memReq      (memReq),
    .memWe       (memWe),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .memRdata    (memRdata),
    .dskReq      (dskReq),
    .dskWe       (dskWe),
    .dskAddr     (dskAddr),
    .dskWdata    (dskWdata),
    .dskRdata    (dskRdata)
  );

endmodule

// File: rtl/sdmaChecker.sv
module sdmaChecker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        memReq,
  input logic        dskReq,
  input logic [15:0] diskAddrOut,
  input logic [17:0] busAddrOut
);

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R1

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || dskReq) |-> busy); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(diskAddrOut) && $stable(busAddrOut))); // R12

  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && dskReq)); // R13

endmodule

bind sectorDmaSeq sdmaChecker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .memReq      (memReq),
  .dskReq      (dskReq),
  .diskAddrOut (diskAddrOut),
  .busAddrOut  (busAddrOut)
);

// File: tb/sectorDmaSeq_tb_top.sv
module sectorDmaSeq_tb_top;

  localparam int TB_SECTORS = 26;
  localparam int TB_DSK_AW  = $clog2(TB_SECTORS * 512);
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] func = '0;
  logic [15:0] diskAddrIn = '0;
  logic [15:0] wordCount = '0;
  logic [17:0] busAddrIn = '0;
  logic inhibitInc = 1'b0;
  logic busy, done, errSector;
  logic [15:0] diskAddrOut;
  logic [17:0] busAddrOut;
  logic [1:0] errCs;
  logic memReq, memWe, dskReq, dskWe;
  logic [17:0] memAddr;
  logic [7:0] memWdata, memRdata, dskWdata, dskRdata;
  logic [TB_DSK_AW-1:0] dskAddr;

  logic [7:0] sysMem [4096];
  logic [7:0] diskMem [2048];
  int accCount = 0;
  int lastDsk = 0;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  sectorDmaSeq #(.DISK_SECTORS(TB_SECTORS)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .func(func),
    .diskAddrIn(diskAddrIn), .wordCount(wordCount), .busAddrIn(busAddrIn),
    .inhibitInc(inhibitInc), .busy(busy), .done(done),
    .diskAddrOut(diskAddrOut), .busAddrOut(busAddrOut),
    .errSector(errSector), .errCs(errCs),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata),
    .dskReq(dskReq), .dskWe(dskWe), .dskAddr(dskAddr),
    .dskWdata(dskWdata), .dskRdata(dskRdata)
  );

  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) sysMem[memAddr[11:0]] <= memWdata;
      else       memRdata <= sysMem[memAddr[11:0]];
    end
    if (dskReq) begin
      lastDsk <= int'(dskAddr);
      if (dskWe) diskMem[dskAddr[10:0]] <= dskWdata;
      else       dskRdata <= diskMem[dskAddr[10:0]];
    end
    if (memReq || dskReq) accCount <= accCount + 1;
  end

  typedef struct packed {
    logic [2:0]  fn;
    logic [15:0] da;
    logic [15:0] wc;
    logic [17:0] ba;
    logic        inh;
    logic [15:0] expDa;
    logic [17:0] expBa;
    logic        expErr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 16'h0000, 16'hFF00, 18'h00100, 1'b0, 16'h0001, 18'h00300, 1'b0}, // R2 negative count, R4
    '{3'd2, 16'h0002, 16'h0100, 18'h00000, 1'b0, 16'h0003, 18'h00200, 1'b0}, // R2 positive count
    '{3'd2, 16'h000B, 16'hFED4, 18'h0FF00, 1'b0, 16'h0011, 18'h10158, 1'b0}, // R4 partial chunk, R5 carry
    '{3'd1, 16'h001B, 16'h0100, 18'h3FF00, 1'b0, 16'h0020, 18'h00100, 1'b0}, // R4 cylinder step, R5 wrap
    '{3'd2, 16'h0022, 16'h0100, 18'h00500, 1'b0, 16'h0022, 18'h00500, 1'b1}, // R8 immediate stop
    '{3'd2, 16'h0021, 16'hFE00, 18'h00200, 1'b0, 16'h0022, 18'h00400, 1'b1}, // R8 stop after one chunk
    '{3'd2, 16'hE005, 16'h0000, 18'h00040, 1'b0, 16'h0005, 18'h00040, 1'b0}, // R10 zero length
    '{3'd1, 16'h6001, 16'h0001, 18'h00010, 1'b0, 16'h0002, 18'h00012, 1'b0}, // R7 drive bits dropped
    '{3'd2, 16'h0000, 16'h0002, 18'h00400, 1'b1, 16'h0001, 18'h00400, 1'b0}, // R6 address held
    '{3'd4, 16'hA123, 16'h0064, 18'h12345, 1'b0, 16'hA123, 18'h12345, 1'b0}, // R11 other function
    '{3'd2, 16'h000D, 16'h0001, 18'h00000, 1'b0, 16'h0010, 18'h00002, 1'b0}, // R4 sector 13 wraps
    '{3'd2, 16'h0000, 16'h8000, 18'h00000, 1'b0, 16'h0022, 18'h03400, 1'b1}  // R2 most negative, R8
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseStart(input logic [2:0] f, input logic [15:0] da,
                            input logic [15:0] wc, input logic [17:0] ba,
                            input logic inh);
    @(negedge clk);
    func = f; diskAddrIn = da; wordCount = wc; busAddrIn = ba; inhibitInc = inh;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n > WATCHDOG) begin
        chk(1'b0, "watchdog", 32'(n), 32'(WATCHDOG));
        break;
      end
    end
  endtask

  initial begin
    int acc0;
    int bad;
    for (int i = 0; i < 4096; i++) sysMem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 2048; i++) diskMem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!busy && !done, "R12 reset busy/done", {30'd0, busy, done}, 0);
    chk(!memReq && !dskReq, "R12 reset requests", {30'd0, memReq, dskReq}, 0);
    chk(diskAddrOut == 0 && busAddrOut == 0 && !errSector && errCs == 0,
        "R12 reset results", {14'd0, busAddrOut}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      acc0 = accCount;
      pulseStart(VECS[v].fn, VECS[v].da, VECS[v].wc, VECS[v].ba, VECS[v].inh);
      waitDone();
      chk(diskAddrOut == VECS[v].expDa, $sformatf("vec%0d disk address", v),
          32'(diskAddrOut), 32'(VECS[v].expDa));
      chk(busAddrOut == VECS[v].expBa, $sformatf("vec%0d bus address", v),
          32'(busAddrOut), 32'(VECS[v].expBa));
      chk({errSector, errCs} == (VECS[v].expErr ? 3'b111 : 3'b000),
          $sformatf("vec%0d R8 error flags", v), 32'({errSector, errCs}),
          VECS[v].expErr ? 32'd7 : 32'd0);
      if (VECS[v].fn != 3'd1 && VECS[v].fn != 3'd2 || VECS[v].wc == 0)
        chk(accCount == acc0, $sformatf("vec%0d R10/R11 no access", v),
            32'(accCount - acc0), 0);
      @(negedge clk);
      chk(!done, "R12 done one cycle", 32'(done), 0);
    end

    // R9: memory to disk, then disk back to a different memory area
    for (int i = 0; i < 256; i++) sysMem[i] = 8'(i * 7 + 3);
    pulseStart(3'd1, 16'h0001, 16'd128, 18'h00000, 1'b0);
    waitDone();
    bad = 0;
    for (int i = 0; i < 256; i++) if (diskMem[512 + i] != 8'(i * 7 + 3)) bad++;
    chk(bad == 0, "R9 write data", 32'(bad), 0);
    for (int i = 0; i < 256; i++) sysMem[12'h800 + i] = 8'h00;
    pulseStart(3'd2, 16'h0001, 16'd128, 18'h00800, 1'b0);
    waitDone();
    bad = 0;
    for (int i = 0; i < 256; i++) if (sysMem[12'h800 + i] != 8'(i * 7 + 3)) bad++;
    chk(bad == 0, "R9 read data", 32'(bad), 0);

    // R6: address held, all four bytes land on 0x900; the last one is disk byte 515
    for (int i = 0; i < 4; i++) sysMem[12'h900 + i] = 8'h00;
    pulseStart(3'd2, 16'h0001, 16'd2, 18'h00900, 1'b1);
    waitDone();
    chk(sysMem[12'h900] == 8'(3 * 7 + 3), "R6 held address last byte",
        32'(sysMem[12'h900]), 32'(8'(3 * 7 + 3)));
    chk(sysMem[12'h901] == 8'h00, "R6 next byte untouched", 32'(sysMem[12'h901]), 0);

    // R3: surface 1 sector 0 is linear sector 12, bytes 6144 and 6145
    pulseStart(3'd2, 16'hC010, 16'd1, 18'h00A00, 1'b0);
    waitDone();
    chk(lastDsk == 6145, "R3 disk byte address", 32'(lastDsk), 32'd6145);

    // R1: a second start while busy is ignored
    pulseStart(3'd2, 16'h0000, 16'h0100, 18'h00100, 1'b0);
    repeat (20) @(negedge clk);
    chk(busy, "R1 busy during transfer", 32'(busy), 1);
    pulseStart(3'd1, 16'h0005, 16'h0001, 18'h00700, 1'b0);
    waitDone();
    chk(diskAddrOut == 16'h0001 && busAddrOut == 18'h00300,
        "R1 start ignored while busy", {14'd0, busAddrOut}, 32'h300);
    @(negedge clk);
    chk(!busy, "R1 idle after done", 32'(busy), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule